// File: doc/BRIEF.md
# SPI Byte Master with Select Timing Guards

This block is a serial peripheral master that exchanges one data word per transfer. It uses the clock format in which the receive side samples on the first clock edge and every other edge after it. A host writes the outgoing word through a write strobe. The block then lowers the active-low select line, clocks the word out on the data-out line and assembles the word arriving on the data-in line. When the exchange ends it raises a completion flag.

The received word only replaces the visible read-data value once the whole word has been shifted in. The previous value stays readable for the full transfer. A read strobe clears the completion flag. Two configuration inputs set the clock level while idle and the bit order; both are latched when a transfer starts. The serial clock runs at a fixed divide of the system clock. `HALF_DIV` system clocks make one half of a serial clock period.

Around every word the block keeps a setup gap, a hold gap and an idle gap, each at least half a serial clock period. The setup gap runs from select falling to the first clock edge. The hold gap runs from the last clock edge to select rising. The idle gap is the time select stays high between words. Writes that arrive too early are dropped.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, ssN is 1, sck equals cfgIdleHigh, doneFlag is 0, rdData is 0 and busy is 0.
- R2: A wrEn pulse seen while busy is 0 and doneFlag is 0 starts a transfer. On the next clock ssN is 0, busy is 1, and mosi carries the first bit of wrData.
- R3: Each transfer makes exactly 16 sck edges, one every HALF_DIV clocks. The first edge comes HALF_DIV clocks after ssN falls.
- R4: The sck level outside the 16 edges is the value of cfgIdleHigh: 0 gives low and 1 gives high. During a transfer the level captured at its start is used.
- R5: When cfgLsbFirst is 0, bit 7 is sent and received first. When it is 1, bit 0 goes first. The setting is captured at the start of the transfer.
- R6: miso is sampled on odd edges 1, 3, ..., 15. mosi moves to the next bit only on even edges 2, 4, ..., 14.
- R7: rdData keeps its old value until the 16th edge. In the clock of that edge rdData takes the received word and doneFlag goes to 1.
- R8: ssN rises HALF_DIV clocks after the 16th edge.
- R9: After ssN rises, busy stays 1 for HALF_DIV more clocks. ssN stays high for at least HALF_DIV+1 clocks between transfers.
- R10: An rdEn pulse clears doneFlag on the next clock, unless the 16th edge happens in that same clock.
- R11: A wrEn pulse while busy is 1 or doneFlag is 1 is ignored: no transfer starts and the word being sent does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgIdleHigh | input | 1 | Idle level of sck (1 = high) |
| cfgLsbFirst | input | 1 | Bit order (1 = bit 0 first) |
| wrEn | input | 1 | Write strobe for the outgoing word |
| wrData | input | 8 | Outgoing word |
| rdEn | input | 1 | Read strobe; clears the completion flag |
| rdData | output | 8 | Last fully received word |
| doneFlag | output | 1 | Transfer complete |
| busy | output | 1 | Transfer or trailing idle gap in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 1 | Active-low select |

## Verification
A bad half-period count or edge counter shows up at sck within HALF_DIV clocks as a misplaced or missing edge. It also leaves ssN rising early or late at the end of the word. Corruption in the shift register appears on mosi at the next even edge, or in rdData at the 16th edge. A completion flag stuck high blocks the next write, so busy and ssN fail to change one clock after that write. A behavioural model in the bench compares every output on every clock, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } xferState_e;

  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic commit;
  } dpStrobe_t;

endpackage

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       cfgIdleHigh,
  input  logic       cfgLsbFirst,
  output dpStrobe_t  strb,
  output logic       lsbFirstQ,
  output logic       ssN,
  output logic       sck,
  output logic       busy,
  output logic       doneFlag
);

  localparam int EDGE_TOTAL = 2 * DATA_W;
  localparam int EDGE_W     = $clog2(EDGE_TOTAL + 1);
  localparam int DIV_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int GAP_W      = $clog2(HALF_DIV + 2);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGE_TOTAL);
  localparam logic [DIV_W-1:0]  DIV_END   = DIV_W'(HALF_DIV - 1);
  localparam logic [GAP_W-1:0]  GAP_MIN   = GAP_W'(HALF_DIV);

  xferState_e        stateQ;
  logic [DIV_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] nextEdge;
  logic              phaseQ;
  logic              polQ;
  logic              ssNQ;
  logic              doneQ;
  logic              tick;
  logic              edgeNow;
  logic              startXfer;
  logic [GAP_W-1:0]  gapCnt;

  assign tick      = (stateQ != ST_IDLE) && (divCnt == DIV_END);
  assign edgeNow   = tick && ((stateQ == ST_LEAD) || (stateQ == ST_SHIFT));
  assign nextEdge  = edgeCnt + 1'b1;
  assign startXfer = wrEn && !doneQ && (stateQ == ST_IDLE);

  always_comb begin
    strb.load   = startXfer;
    strb.sample = edgeNow && nextEdge[0];
    strb.shift  = edgeNow && !nextEdge[0] && (nextEdge != LAST_EDGE);
    strb.commit = edgeNow && (nextEdge == LAST_EDGE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      divCnt    <= '0;
      edgeCnt   <= '0;
      phaseQ    <= 1'b0;
      polQ      <= 1'b0;
      lsbFirstQ <= 1'b0;
      ssNQ      <= 1'b1;
      doneQ     <= 1'b0;
    end else begin
      if (stateQ == ST_IDLE || tick) divCnt <= '0;
      else                           divCnt <= divCnt + 1'b1;

      if (strb.commit)  doneQ <= 1'b1;
      else if (rdEn)    doneQ <= 1'b0;

      if (edgeNow) begin
        edgeCnt <= nextEdge;
        phaseQ  <= ~phaseQ;
      end

      unique case (stateQ)
        ST_IDLE: if (startXfer) begin
          stateQ    <= ST_LEAD;
          ssNQ      <= 1'b0;
          edgeCnt   <= '0;
          phaseQ    <= 1'b0;
          polQ      <= cfgIdleHigh;
          lsbFirstQ <= cfgLsbFirst;
        end
        ST_LEAD:  if (tick) stateQ <= ST_SHIFT;
        ST_SHIFT: if (strb.commit) stateQ <= ST_TRAIL;
        ST_TRAIL: if (tick) begin
          stateQ <= ST_GAP;
          ssNQ   <= 1'b1;
        end
        ST_GAP:   if (tick) stateQ <= ST_IDLE;
        default:  stateQ <= ST_IDLE;
      endcase
    end
  end

  // Length of the current select-high stretch, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             gapCnt <= GAP_MIN;
    else if (!ssNQ)        gapCnt <= '0;
    else if (gapCnt < GAP_MIN) gapCnt <= gapCnt + 1'b1;
  end

  assign busy     = (stateQ != ST_IDLE);
  assign ssN      = ssNQ;
  assign doneFlag = doneQ;
  assign sck      = (busy ? polQ : cfgIdleHigh) ^ phaseQ;

  assert_edges_before_trail_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_TRAIL) |-> (edgeCnt == LAST_EDGE));

  assert_idle_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssNQ) |-> (gapCnt >= GAP_MIN));

  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && stateQ != ST_SHIFT) |=> !doneQ);

  assert_write_dropped_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && doneQ && stateQ == ST_IDLE) |=> (stateQ == ST_IDLE && ssNQ));

  assert_ss_low_while_clocking_R3: assert property (@(posedge clk) disable iff (!rstN)
    edgeNow |-> !ssNQ);

endmodule

// File: rtl/spi_xfer_dpath.sv
module spi_xfer_dpath
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              lsbFirstQ,
  input  logic [DATA_W-1:0] wrData,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] shiftQ;
  logic [DATA_W-1:0] shiftNext;
  logic [DATA_W-1:0] assembled;
  logic              rxBitQ;
  logic [DATA_W-1:0] rdQ;

  always_comb begin
    if (lsbFirstQ) begin
      shiftNext = {rxBitQ, shiftQ[DATA_W-1:1]};
      assembled = {rxBitQ, shiftQ[DATA_W-1:1]};
    end else begin
      shiftNext = {shiftQ[DATA_W-2:0], rxBitQ};
      assembled = {shiftQ[DATA_W-2:0], rxBitQ};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxBitQ <= 1'b0;
      rdQ    <= '0;
    end else begin
      if (strb.load)        shiftQ <= wrData;
      else if (strb.shift)  shiftQ <= shiftNext;
      if (strb.sample)      rxBitQ <= miso;
      if (strb.commit)      rdQ    <= assembled;
    end
  end

  assign mosi   = lsbFirstQ ? shiftQ[0] : shiftQ[DATA_W-1];
  assign rdData = rdQ;

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.sample, strb.shift, strb.commit}));

  assert_mosi_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.shift) |=> $stable(mosi));

  assert_rd_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(rdData));

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgIdleHigh,
  input  logic              cfgLsbFirst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              doneFlag,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ssN
);

  dpStrobe_t strb;
  logic      lsbFirstQ;

  spi_xfer_ctrl #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .cfgIdleHigh(cfgIdleHigh), .cfgLsbFirst(cfgLsbFirst),
    .strb(strb), .lsbFirstQ(lsbFirstQ), .ssN(ssN), .sck(sck),
    .busy(busy), .doneFlag(doneFlag)
  );

  spi_xfer_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .lsbFirstQ(lsbFirstQ),
    .wrData(wrData), .miso(miso), .mosi(mosi), .rdData(rdData)
  );

endmodule

// File: tb/test_spi_xfer_master.sv
module test_spi_xfer_master;

  localparam int H = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgIdleHigh = 1'b0;
  logic       cfgLsbFirst = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b0;
  logic       miso = 1'b0;
  logic [7:0] rdData;
  logic       doneFlag, busy, sck, mosi, ssN;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  spi_xfer_master #(.DATA_W(8), .HALF_DIV(H)) i_spi_xfer_master (
    .clk(clk), .rstN(rstN), .cfgIdleHigh(cfgIdleHigh), .cfgLsbFirst(cfgLsbFirst),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .doneFlag(doneFlag), .busy(busy), .sck(sck), .mosi(mosi), .miso(miso), .ssN(ssN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Pseudo-random slave data on miso.
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[0];
  end

  // Behavioural model.
  bit mBusy = 0, mDone = 0, mSsN = 1, mPhase = 0, mPol = 0, mLsb = 0;
  int mT = 0, mIdx = 0;
  logic [7:0] mTx = 0, mRx = 0, mRd = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mSsN = 1; mPhase = 0; mRd = 0; mRx = 0;
    end else begin
      bit oldDone;
      oldDone = mDone;
      if (rdEn) mDone = 0;
      if (mBusy) begin
        mT++;
        if (mT % H == 0) begin
          int n;
          n = mT / H;
          if (n <= 16) begin
            mPhase = !mPhase;
            if (n % 2 == 1) begin
              if (mLsb) mRx = {miso, mRx[7:1]};
              else      mRx = {mRx[6:0], miso};
            end else if (n < 16) mIdx++;
            if (n == 16) begin mDone = 1; mRd = mRx; end
          end
          if (n == 17) mSsN = 1;
          if (n == 18) mBusy = 0;
        end
      end else if (wrEn && !oldDone) begin
        mBusy = 1; mT = 0; mSsN = 0; mTx = wrData; mIdx = 0;
        mPol = cfgIdleHigh; mLsb = cfgLsbFirst; mPhase = 0;
      end
    end
  end

  // Timing monitors and per-cycle comparison.
  bit   sckPrev = 0, ssPrev = 1;
  int   edgesSeen = 0, lastEdgeCyc = 0, ssHighRun = 100;
  bit   sawTransfer = 0;

  always @(negedge clk) begin
    if (rstN) begin
      check("R8 ssN", ssN, mSsN);
      check("R3 R4 sck", sck, (mBusy ? mPol : cfgIdleHigh) ^ mPhase);
      check("R7 doneFlag", doneFlag, mDone);
      check("R5 R7 rdData", rdData, mRd);
      check("R9 busy", busy, mBusy);
      if (!mSsN) check("R5 R6 mosi", mosi, mLsb ? mTx[mIdx] : mTx[7 - mIdx]);

      if (!ssN && sck != sckPrev) begin edgesSeen++; lastEdgeCyc = cyc; end
      if (ssPrev && !ssN) begin
        if (sawTransfer) check("R9 idle gap ok", ssHighRun >= H + 1, 1);
        edgesSeen = 0;
        sawTransfer = 1;
      end
      if (!ssPrev && ssN) begin
        check("R3 edge count", edgesSeen, 16);
        check("R8 trail time", cyc - lastEdgeCyc, H);
      end
      ssHighRun = ssN ? ssHighRun + 1 : 0;
      sckPrev = sck;
      ssPrev  = ssN;
    end
  end

  task automatic tickDrive();
    @(posedge clk); #1;
  endtask

  task automatic writeWord(input logic [7:0] d);
    tickDrive(); wrEn = 1; wrData = d;
    tickDrive(); wrEn = 0;
  endtask

  task automatic readWord();
    tickDrive(); rdEn = 1;
    tickDrive(); rdEn = 0;
  endtask

  task automatic waitDone();
    int guard = 0;
    while (!doneFlag && guard < 1000) begin @(negedge clk); guard++; end
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 1000) begin @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check("R1 ssN", ssN, 1);
    check("R1 sck", sck, 0);
    check("R1 doneFlag", doneFlag, 0);
    check("R1 rdData", rdData, 0);
    check("R1 busy", busy, 0);

    // R2: MSB first, idle low
    writeWord(8'hA5);
    @(negedge clk);
    check("R2 ssN low after write", ssN, 0);
    // R11: write while busy is ignored
    tickDrive(); wrEn = 1; wrData = 8'h0F;
    tickDrive(); wrEn = 0;
    waitDone();
    check("R7 done set", doneFlag, 1);
    waitIdle();
    // R11: write while done still set is ignored
    writeWord(8'h77);
    @(negedge clk);
    check("R11 no start while done", busy, 0);
    readWord();
    @(negedge clk);
    check("R10 done cleared", doneFlag, 0);

    // R4, R5: idle high, LSB first; cfg changed mid-transfer
    tickDrive(); cfgIdleHigh = 1; cfgLsbFirst = 1;
    @(negedge clk);
    check("R4 idle high", sck, 1);
    writeWord(8'h3C);
    repeat (4) tickDrive();
    cfgIdleHigh = 0; cfgLsbFirst = 0;
    waitDone();
    waitIdle();
    readWord();

    // R9: back-to-back writes held high
    tickDrive(); cfgIdleHigh = 1; cfgLsbFirst = 0;
    tickDrive(); wrEn = 1; wrData = 8'hC3;
    waitDone();
    #1 rdEn = 1;
    @(posedge clk); #1 rdEn = 0; wrData = 8'h5A;
    while (ssN == 0) @(negedge clk);
    while (ssN == 1) @(negedge clk);
    #1 wrEn = 0;
    waitDone();
    readWord();
    waitIdle();
    repeat (5) tickDrive();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule